// File: doc/BRIEF.md
# Split-Channel Burst Memory Slave

This block is a memory-backed slave for a bus whose request, read-data and write-data traffic travel on three independent channels. A master raises a request flag together with a read/write select and a word address. The slave takes the request with a grant and places it in a small in-order queue. Each request that is taken becomes one fixed burst of four data beats. A read burst runs on the read channel and a write burst on the write channel. Write beats carry a per-byte mask into a word-wide RAM.

Bursts are served one at a time, in the order they were granted. A burst-sequencing state machine has three states. `ST_IDLE` means no burst is active. `ST_READ` means a read burst holds the read acknowledge high. `ST_WRITE` means a write burst holds the write acknowledge high. There are three transitions:
- load: the machine leaves `ST_IDLE` when the queue holds an entry.
- finish: the machine returns to `ST_IDLE` when the last beat transfers or the master aborts, and the queue is empty.
- chain: the machine goes directly into the next queued burst when it finishes or aborts and the queue still holds an entry.

Because service is strictly serial, a write queued behind a read to the same address is held until that read burst has ended.

Either channel can be cut short by the master with an abort input, which discards the rest of the active burst. Beats that already transferred stay in effect.

Top module: `sc_burst_slave`

## Requirements
- R1: While reset is asserted and right after it, `rq_grant` is 1, and `rd_ack` and `wr_ack` are 0.
- R2: The queue holds up to 4 waiting requests besides the active burst. `rq_grant` is 1 exactly when the queue is not full. With one burst active and 4 requests waiting, `rq_grant` is 0, and a request presented while `rq_grant` is 0 is not taken.
- R3: Each granted request produces one burst of 4 beats. A beat transfers only at a clock edge where the strobe and the acknowledge of its channel are both 1. For a read, `rd_data` holds the addressed word in the same cycle as `rd_ack`.
- R4: Beat k of a burst addresses word (start + k) modulo 64, so a burst that starts at word 62 covers words 62, 63, 0 and 1.
- R5: On a write beat, bit i of `wr_be` enables bits 8i+7..8i of `wr_data`. Lanes whose bit is 0 keep their previous content.
- R6: Requests are served in grant order, one burst at a time. `rd_ack` and `wr_ack` are never 1 together.
- R7: `rd_abort` sampled high while `rd_ack` is 1 ends the read burst at that edge. If another request is queued, its acknowledge is 1 in the very next cycle.
- R8: `wr_abort` sampled high while `wr_ack` is 1 ends the write burst at that edge. A beat presented in the same cycle as the abort is not written, and earlier beats of the burst remain written.
- R9: An abort while no burst of that channel is active has no effect. The next burst still runs all 4 beats.
- R10: A write queued behind a read to the same address keeps `wr_ack` at 0 while the read burst runs. The read returns the data from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rq_valid | input | 1 | Request flag from the master |
| rq_write | input | 1 | 1 = write burst, 0 = read burst; valid with `rq_valid` |
| rq_addr | input | 6 | Start word address; valid with `rq_valid` |
| rq_grant | output | 1 | Slave can take a request this cycle |
| rd_strobe | input | 1 | Master can take a read beat |
| rd_abort | input | 1 | Master aborts the active read burst |
| rd_ack | output | 1 | Read burst active, `rd_data` valid |
| rd_data | output | 32 | Read beat data |
| wr_strobe | input | 1 | Write beat presented |
| wr_abort | input | 1 | Master aborts the active write burst |
| wr_data | input | 32 | Write beat data |
| wr_be | input | 4 | Per-byte write enables |
| wr_ack | output | 1 | Write burst active, slave takes beats |

## Verification
When the slave is idle, a request taken at edge n makes its acknowledge rise after edge n+1. Read data is valid in the same cycle as `rd_ack`. A write beat takes effect at its transfer edge and is seen by a later read burst. After a last beat or an abort at edge n, the next queued burst's acknowledge is high after that same edge. The grant falls after the edge that takes the fifth outstanding request. The bench drives and samples only at falling edges. A read beat is compared when `rd_ack` is seen high at the falling edge before its transfer edge. The immediate checks for R2, R7 and R10 are placed in the first cycle after the edge that is due to cause them.

// File: rtl/scb_pkg.sv
package scb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } svc_state_e;

    function automatic int lane_count(input int data_w);
        return data_w / 8;
    endfunction

endpackage

// File: rtl/scb_req_queue.sv
module scb_req_queue #(
    parameter int WIDTH = 7,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slots[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else if (do_push) begin
            slots[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/scb_burst_fsm.sv
module scb_burst_fsm
    import scb_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int BURST_LEN = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         head_valid,
    input  logic                         head_write,
    input  logic [ADDR_W-1:0]            head_addr,
    output logic                         pop,
    input  logic                         rd_strobe,
    input  logic                         rd_abort,
    input  logic                         wr_strobe,
    input  logic                         wr_abort,
    output logic                         rd_ack,
    output logic                         wr_ack,
    output logic                         mem_we,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [$clog2(BURST_LEN)-1:0] beat
);

    localparam int BEAT_W = $clog2(BURST_LEN);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

    svc_state_e        state_q;
    svc_state_e        state_d;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic              rd_fin;
    logic              wr_fin;
    logic              rd_go;
    logic              wr_go;
    logic              load;

    // next-state: load, finish and chain transitions
    always_comb begin
        rd_fin  = 1'b0;
        wr_fin  = 1'b0;
        rd_go   = 1'b0;
        wr_go   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_READ: begin
                rd_fin = rd_abort || (rd_strobe && beat_q == LAST_BEAT);
                rd_go  = rd_strobe && !rd_abort;
            end
            ST_WRITE: begin
                wr_fin = wr_abort || (wr_strobe && beat_q == LAST_BEAT);
                wr_go  = wr_strobe && !wr_abort;
            end
            default: begin
            end
        endcase
        load    = head_valid && (state_q == ST_IDLE || rd_fin || wr_fin);
        state_d = state_q;
        if (load) begin
            state_d = head_write ? ST_WRITE : ST_READ;
        end else if (rd_fin || wr_fin) begin
            state_d = ST_IDLE;
        end
    end

    // state register and burst position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                base_q <= head_addr;
                beat_q <= '0;
            end else if (rd_fin || wr_fin) begin
                beat_q <= '0;
            end else if (rd_go || wr_go) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        rd_ack = 1'b0;
        wr_ack = 1'b0;
        mem_we = 1'b0;
        unique case (state_q)
            ST_READ: begin
                rd_ack = 1'b1;
            end
            ST_WRITE: begin
                wr_ack = 1'b1;
                mem_we = wr_strobe && !wr_abort;
            end
            default: begin
            end
        endcase
    end

    assign pop      = load;
    assign mem_addr = base_q + ADDR_W'(beat_q);
    assign beat     = beat_q;

endmodule

// File: rtl/scb_mem.sv
module scb_mem
    import scb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                we,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_be
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int LANES = lane_count(DATA_W);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [7:0] cells [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int w = 0; w < DEPTH; w++) begin
                    cells[w] <= '0;
                end
            end else if (we && wr_be[ln]) begin
                cells[addr] <= wr_data[ln*8 +: 8];
            end
        end

        assign rd_data[ln*8 +: 8] = cells[addr];
    end

endmodule

// File: rtl/sc_burst_slave.sv
module sc_burst_slave #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 32,
    parameter int QUEUE_DEPTH = 4,
    parameter int BURST_LEN   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rq_valid,
    input  logic                rq_write,
    input  logic [ADDR_W-1:0]   rq_addr,
    output logic                rq_grant,
    input  logic                rd_strobe,
    input  logic                rd_abort,
    output logic                rd_ack,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                wr_strobe,
    input  logic                wr_abort,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_be,
    output logic                wr_ack
);

    localparam int ENTRY_W = ADDR_W + 1;
    localparam int CNT_W   = $clog2(QUEUE_DEPTH + 1);
    localparam int BEAT_W  = $clog2(BURST_LEN);

    logic [ENTRY_W-1:0] head;
    logic               q_full;
    logic               q_empty;
    logic [CNT_W-1:0]   q_count;
    logic               q_pop;
    logic               mem_we;
    logic [ADDR_W-1:0]  mem_addr;
    logic [BEAT_W-1:0]  beat;

    assign rq_grant = !q_full;

    scb_req_queue #(
        .WIDTH (ENTRY_W),
        .DEPTH (QUEUE_DEPTH)
    ) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rq_valid && rq_grant),
        .din   ({rq_write, rq_addr}),
        .pop   (q_pop),
        .dout  (head),
        .full  (q_full),
        .empty (q_empty),
        .count (q_count)
    );

    scb_burst_fsm #(
        .ADDR_W    (ADDR_W),
        .BURST_LEN (BURST_LEN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (!q_empty),
        .head_write (head[ENTRY_W-1]),
        .head_addr  (head[ADDR_W-1:0]),
        .pop        (q_pop),
        .rd_strobe  (rd_strobe),
        .rd_abort   (rd_abort),
        .wr_strobe  (wr_strobe),
        .wr_abort   (wr_abort),
        .rd_ack     (rd_ack),
        .wr_ack     (wr_ack),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .beat       (beat)
    );

    scb_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (mem_addr),
        .rd_data (rd_data),
        .we      (mem_we),
        .wr_data (wr_data),
        .wr_be   (wr_be)
    );

endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
    parameter int QUEUE_DEPTH = 4,
    parameter int BURST_LEN   = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             rq_grant,
    input logic [$clog2(QUEUE_DEPTH+1)-1:0] q_count,
    input logic                             rd_strobe,
    input logic                             rd_abort,
    input logic                             rd_ack,
    input logic                             wr_strobe,
    input logic                             wr_abort,
    input logic                             wr_ack,
    input logic [$clog2(BURST_LEN)-1:0]     beat
);

    localparam int BEAT_W = $clog2(BURST_LEN);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_count) <= QUEUE_DEPTH);

    assert_grant_when_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(q_count) < QUEUE_DEPTH) |-> rq_grant);

    assert_one_channel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ack && wr_ack));

    assert_read_end_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_ack) |-> $past(rd_abort || (rd_strobe && beat == LAST_BEAT)));

    assert_beat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !rd_strobe && !rd_abort) |=> $stable(beat));

    assert_full_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && rd_strobe && !rd_abort && beat == LAST_BEAT) |=> (beat == '0));

    assert_read_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && rd_abort) |=> (beat == '0));

    assert_write_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && wr_abort) |=> (beat == '0));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ack && !wr_ack && q_count == '0) |=> (!rd_ack && !wr_ack));

    assert_write_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && wr_strobe && !wr_abort && beat != LAST_BEAT) |=> (wr_ack && beat == $past(beat) + 1'b1));

endmodule

bind sc_burst_slave scb_checker #(
    .QUEUE_DEPTH (QUEUE_DEPTH),
    .BURST_LEN   (BURST_LEN)
) u_scb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rq_grant  (rq_grant),
    .q_count   (q_count),
    .rd_strobe (rd_strobe),
    .rd_abort  (rd_abort),
    .rd_ack    (rd_ack),
    .wr_strobe (wr_strobe),
    .wr_abort  (wr_abort),
    .wr_ack    (wr_ack),
    .beat      (beat)
);

// File: tb/test_sc_burst_slave.sv
`timescale 1ns/1ps
module test_sc_burst_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rq_valid = 1'b0;
    logic        rq_write = 1'b0;
    logic [5:0]  rq_addr = '0;
    logic        rq_grant;
    logic        rd_strobe = 1'b0;
    logic        rd_abort = 1'b0;
    logic        rd_ack;
    logic [31:0] rd_data;
    logic        wr_strobe = 1'b0;
    logic        wr_abort = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        wr_ack;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [31:0] shadow [64];
    int          rd_plan [$];
    logic [31:0] rd_exp  [$];
    int          wr_plan [$];
    logic [31:0] wr_dq   [$];
    logic [3:0]  wr_beq  [$];
    bit rd_hold = 1'b0;
    bit wr_hold = 1'b0;
    bit rd_busy = 1'b0;
    bit wr_busy = 1'b0;
    bit chk_b2b = 1'b0;

    always #2.5 clk = ~clk;

    sc_burst_slave i_sc_burst_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .rq_valid  (rq_valid),
        .rq_write  (rq_write),
        .rq_addr   (rq_addr),
        .rq_grant  (rq_grant),
        .rd_strobe (rd_strobe),
        .rd_abort  (rd_abort),
        .rd_ack    (rd_ack),
        .rd_data   (rd_data),
        .wr_strobe (wr_strobe),
        .wr_abort  (wr_abort),
        .wr_data   (wr_data),
        .wr_be     (wr_be),
        .wr_ack    (wr_ack)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue_req(input bit w, input int a);
        rq_valid = 1'b1;
        rq_write = w;
        rq_addr  = 6'(a);
        while (!rq_grant) @(negedge clk);
        @(negedge clk);
        rq_valid = 1'b0;
    endtask

    // driver: expected read words come from the shadow at request time
    task automatic push_read(input int a, input int n);
        for (int i = 0; i < n; i++) begin
            rd_exp.push_back(shadow[(a + i) & 63]);
        end
        rd_plan.push_back(n);
        issue_req(1'b0, a);
    endtask

    task automatic push_write(input int a, input logic [31:0] base, input logic [3:0] be, input int n);
        int beats;
        beats = (n < 4) ? n + 1 : 4;
        for (int i = 0; i < beats; i++) begin
            logic [31:0] d;
            d = base + 32'(i) * 32'h0101_0101;
            wr_dq.push_back(d);
            if (i < n) begin
                for (int l = 0; l < 4; l++) begin
                    if (be[l]) shadow[(a + i) & 63][l*8 +: 8] = d[l*8 +: 8];
                end
            end
        end
        wr_beq.push_back(be);
        wr_plan.push_back(n);
        issue_req(1'b1, a);
    endtask

    // monitor on the read channel: compares each beat before its transfer edge
    task automatic run_read(input int n);
        int got = 0;
        while (got < n) begin
            rd_strobe = 1'b1;
            while (!rd_ack) @(negedge clk);
            check_eq("R3/R4/R5 read beat", rd_data, rd_exp.pop_front());
            got++;
            @(negedge clk);
        end
        rd_strobe = 1'b0;
        if (n < 4) begin
            rd_abort = 1'b1;
            @(negedge clk);
            rd_abort = 1'b0;
            if (chk_b2b) begin
                check_eq("R7 next burst ack after abort", 32'(wr_ack), 32'd1);
                chk_b2b = 1'b0;
            end
        end
    endtask

    task automatic run_write(input int n);
        int got = 0;
        wr_be = wr_beq.pop_front();
        while (got < n) begin
            wr_data   = wr_dq.pop_front();
            wr_strobe = 1'b1;
            while (!wr_ack) @(negedge clk);
            got++;
            @(negedge clk);
        end
        wr_strobe = 1'b0;
        if (n < 4) begin
            wr_data   = wr_dq.pop_front();
            wr_strobe = 1'b1;
            wr_abort  = 1'b1;
            @(negedge clk);
            wr_strobe = 1'b0;
            wr_abort  = 1'b0;
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (!rd_hold && rd_plan.size() > 0) begin
                rd_busy = 1'b1;
                run_read(rd_plan.pop_front());
                rd_busy = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (!wr_hold && wr_plan.size() > 0) begin
                wr_busy = 1'b1;
                run_write(wr_plan.pop_front());
                wr_busy = 1'b0;
            end
        end
    end

    task automatic drain();
        do @(negedge clk);
        while (rd_plan.size() > 0 || wr_plan.size() > 0 || rd_busy || wr_busy || rd_ack || wr_ack);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        check_eq("R1 grant in reset", 32'(rq_grant), 32'd1);
        check_eq("R1 rd_ack in reset", 32'(rd_ack), 32'd0);
        check_eq("R1 wr_ack in reset", 32'(wr_ack), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 grant after reset", 32'(rq_grant), 32'd1);
        check_eq("R1 acks after reset", 32'({rd_ack, wr_ack}), 32'd0);

        // R3 R5: full write then read back
        push_write(8, 32'hA0B1_C2D3, 4'hF, 4);
        push_read(8, 4);
        drain();

        // R5: partial byte mask merges with old content
        push_write(8, 32'h1234_5678, 4'b0101, 4);
        push_read(8, 4);
        drain();

        // R4: burst wraps past word 63
        push_write(62, 32'h5500_00AA, 4'hF, 4);
        push_read(62, 4);
        push_read(0, 2);
        drain();

        // R2: fill the queue with the read channel held
        rd_hold = 1'b1;
        for (int k = 0; k < 5; k++) push_read(8 + k, 4);
        check_eq("R2 grant low when full", 32'(rq_grant), 32'd0);
        rq_valid = 1'b1;
        rq_write = 1'b1;
        rq_addr  = 6'd33;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_eq("R2 grant stays low", 32'(rq_grant), 32'd0);
        end
        rq_valid = 1'b0;
        rd_hold  = 1'b0;
        drain();
        check_eq("R2 refused request not served", 32'({rd_ack, wr_ack}), 32'd0);

        // R7 R6: read aborted after 2 beats, queued write starts next cycle
        rd_hold = 1'b1;
        wr_hold = 1'b1;
        push_read(20, 2);
        push_write(30, 32'hC0DE_0001, 4'hF, 4);
        chk_b2b = 1'b1;
        rd_hold = 1'b0;
        wr_hold = 1'b0;
        drain();
        push_read(30, 4);
        drain();

        // R8: write aborted after 1 beat, abort beat not written
        push_write(40, 32'h7777_0000, 4'hF, 1);
        push_read(40, 4);
        drain();

        // R9: aborts while idle have no effect
        rd_abort = 1'b1;
        wr_abort = 1'b1;
        repeat (2) @(negedge clk);
        rd_abort = 1'b0;
        wr_abort = 1'b0;
        check_eq("R9 idle acks after abort", 32'({rd_ack, wr_ack}), 32'd0);
        push_read(8, 4);
        drain();

        // R10: write behind a read to the same address waits
        rd_hold = 1'b1;
        push_read(50, 4);
        push_write(50, 32'hFEED_0000, 4'hF, 4);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check_eq("R10 read active", 32'(rd_ack), 32'd1);
            check_eq("R10 write held", 32'(wr_ack), 32'd0);
        end
        rd_hold = 1'b0;
        drain();
        push_read(50, 4);
        drain();

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule